// File: doc/BRIEF.md
# FPU State Save/Restore Sequencer

This block moves the architectural state of a floating-point unit between its register file and memory, one byte per handshake beat. Four operations are offered: a full save, a full restore, an environment-only store and an environment-only load. The environment is the control, status and tag words plus the last instruction pointer and the last operand address. A full save or restore also carries the eight data registers. A completed full save also requests a reinitialization of the unit.

A mode input chooses one of two layouts. The wide layout gives each environment item a 4-byte slot. The narrow layout packs the environment into seven 16-bit words. Restore and load read back exactly the layout that the matching store wrote. State is read through plain input ports and a data-register read port. On a restore it is written back one field at a time through a select-coded write port.

Top module: `fpu_state_xfer`

## Requirements
- R1: After reset, busy, done, initPulse, memReq and rfWrEn are all low.
- R2: A start pulse is accepted only while busy is low; a start seen while busy has no effect. Busy is high from the cycle after acceptance until the final beat is acknowledged, and done is a one-cycle pulse in the next cycle, with busy already low.
- R3: memReq is high while busy. memAddr, memWe and (for writes) memWdata hold steady until memAck. Each acknowledged beat moves exactly one byte, and addresses run baseAddr, baseAddr+1, ... with no gaps.
- R4: op encoding: 0 full save, 1 full restore, 2 environment store, 3 environment load; memWe is high for codes 0 and 2.
- R5: Wide layout (wide32=1): seven 4-byte little-endian slots in this order: control, status, tag, instruction pointer, a zero slot, operand address, a zero slot. The 16-bit words fill only the low half of their slots, and the upper half is written as zero.
- R6: Narrow layout (wide32=0): seven little-endian 16-bit words in the same order, holding the low 16 bits of the instruction pointer and the operand address, with nothing in between.
- R7: A full save or restore follows the environment with the eight 80-bit data registers in physical order 0 to 7, 10 bytes each, little-endian, for a total of 108 bytes (wide) or 94 bytes (narrow). The environment-only operations transfer exactly 28 or 14 bytes.
- R8: initPulse rises together with done after a full save, and never after any other operation.
- R9: A restore or load writes each field once through rfWrEn, one cycle after the field's last byte. rfWrSel codes are 0-7 for a data register, 8 control, 9 status, 10 tag, 11 instruction pointer, 12 operand address. Zero slots and upper slot halves are ignored, and in the narrow layout the pointer fields are zero-extended.
- R10: An environment load writes no data register and makes no memory write. An environment store leaves the memory byte just past its 28 or 14 bytes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | Operation code |
| wide32 | input | 1 | 1 selects the wide layout, 0 the narrow layout |
| baseAddr | input | ADDR_W | First byte address of the image |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| initPulse | output | 1 | Reinitialize request after a full save |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | ADDR_W | Beat byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with memAck |
| memAck | input | 1 | Beat accepted |
| ctlWord | input | 16 | Current control word |
| statWord | input | 16 | Current status word |
| tagWord | input | 16 | Current tag word |
| instPtr | input | 32 | Last instruction pointer |
| opdAddr | input | 32 | Last operand address |
| rfRdIdx | output | log2(NUM_REGS) | Data register being read |
| rfRdData | input | REG_W | Contents of register rfRdIdx |
| rfWrEn | output | 1 | Field write strobe |
| rfWrSel | output | 4 | Field being written |
| rfWrData | output | REG_W | Field value, zero-extended |

## Verification
Most faults in the byte, register or slot counters appear at the ports within one beat. The next write byte comes from the wrong field or position, or the address step breaks, so a byte-by-byte comparison of the image catches them at once. A wrong terminal count shows only at the end of the transfer, as a total beat count other than 108, 94, 28 or 14, or as a changed byte just past the image. Faults on the restore side show one cycle after a field's last byte, as a wrong value written to a field, a wrong field select, a missing zero-extension, or a write to a data register during an environment load.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

  typedef enum logic [1:0] {
    XO_SAVE      = 2'd0,
    XO_RESTORE   = 2'd1,
    XO_ENV_STORE = 2'd2,
    XO_ENV_LOAD  = 2'd3
  } xferOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // latch base/mode, clear counters
    logic beat;    // one byte accepted by memory
    logic inRegs;  // data-register phase (else environment phase)
  } seqStrobe_t;

  localparam int ENV_SLOTS = 7;
  localparam logic [3:0] SEL_CTL  = 4'd8;
  localparam logic [3:0] SEL_STAT = 4'd9;
  localparam logic [3:0] SEL_TAG  = 4'd10;
  localparam logic [3:0] SEL_IP   = 4'd11;
  localparam logic [3:0] SEL_OPD  = 4'd12;

endpackage

// File: rtl/fpst_ctrl.sv
module fpst_ctrl
  import fpst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] opIn,
  input  logic       envLast,
  input  logic       regLast,
  input  logic       memAck,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       initPulse,
  output logic       memReq,
  output logic       memWe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ENV, ST_REGS} seqState_e;

  seqState_e stateQ;
  xferOp_e   opQ;
  logic      fullOp;

  assign fullOp = (opQ == XO_SAVE) || (opQ == XO_RESTORE);

  always_comb begin
    strb        = '0;
    strb.load   = (stateQ == ST_IDLE) && start;
    strb.beat   = (stateQ != ST_IDLE) && memAck;
    strb.inRegs = (stateQ == ST_REGS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ    <= ST_IDLE;
      opQ       <= XO_SAVE;
      done      <= 1'b0;
      initPulse <= 1'b0;
    end else begin
      done      <= 1'b0;
      initPulse <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            opQ    <= xferOp_e'(opIn);
            stateQ <= ST_ENV;
          end
        end
        ST_ENV: begin
          if (memAck && envLast) begin
            if (fullOp) begin
              stateQ <= ST_REGS;
            end else begin
              stateQ <= ST_IDLE;
              done   <= 1'b1;
            end
          end
        end
        ST_REGS: begin
          if (memAck && regLast) begin
            stateQ    <= ST_IDLE;
            done      <= 1'b1;
            initPulse <= (opQ == XO_SAVE);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (stateQ != ST_IDLE);
  assign memReq = busy;
  assign memWe  = (opQ == XO_SAVE) || (opQ == XO_ENV_STORE);

endmodule

// File: rtl/fpst_dp.sv
module fpst_dp
  import fpst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seqStrobe_t                  strb,
  input  logic                        isWrite,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic                        wide32,
  input  logic [15:0]                 ctlWord,
  input  logic [15:0]                 statWord,
  input  logic [15:0]                 tagWord,
  input  logic [31:0]                 instPtr,
  input  logic [31:0]                 opdAddr,
  input  logic [REG_W-1:0]            rfRdData,
  input  logic [7:0]                  memRdata,
  output logic                        envLast,
  output logic                        regLast,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [7:0]                  memWdata,
  output logic [$clog2(NUM_REGS)-1:0] rfRdIdx,
  output logic                        rfWrEn,
  output logic [3:0]                  rfWrSel,
  output logic [REG_W-1:0]            rfWrData
);

  localparam int REG_BYTES = REG_W / 8;
  localparam int RB_W      = $clog2(REG_BYTES);
  localparam int RI_W      = $clog2(NUM_REGS);
  localparam int EC_W      = $clog2(4 * ENV_SLOTS);
  localparam logic [EC_W-1:0] ENV_LAST_W = EC_W'(4 * ENV_SLOTS - 1);
  localparam logic [EC_W-1:0] ENV_LAST_N = EC_W'(2 * ENV_SLOTS - 1);
  localparam logic [RB_W-1:0] RB_LAST    = RB_W'(REG_BYTES - 1);
  localparam logic [RI_W-1:0] RI_LAST    = RI_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] baseQ, offQ;
  logic              wideQ;
  logic [EC_W-1:0]   envCnt;
  logic [RB_W-1:0]   regByte;
  logic [RI_W-1:0]   regIdx;
  logic [REG_W-1:0]  asmQ, asmNext;
  logic              wrPendQ;
  logic [3:0]        wrSelQ;

  logic [2:0]        slot;
  logic [1:0]        byteSel;
  logic [31:0]       slotVal;
  logic [RB_W-1:0]   pos;
  logic              fieldFirst, fieldEnd, fieldValid;
  logic [3:0]        fieldSel;

  // Environment position: slot index and byte within slot
  assign slot    = wideQ ? envCnt[4:2] : envCnt[3:1];
  assign byteSel = wideQ ? envCnt[1:0] : {1'b0, envCnt[0]};

  assign envLast = wideQ ? (envCnt == ENV_LAST_W) : (envCnt == ENV_LAST_N);
  assign regLast = (regIdx == RI_LAST) && (regByte == RB_LAST);

  always_comb begin
    slotVal    = '0;
    fieldSel   = SEL_CTL;
    fieldValid = 1'b0;
    case (slot)
      3'd0: begin slotVal = {16'h0, ctlWord};  fieldSel = SEL_CTL;  fieldValid = 1'b1; end
      3'd1: begin slotVal = {16'h0, statWord}; fieldSel = SEL_STAT; fieldValid = 1'b1; end
      3'd2: begin slotVal = {16'h0, tagWord};  fieldSel = SEL_TAG;  fieldValid = 1'b1; end
      3'd3: begin
        slotVal    = wideQ ? instPtr : {16'h0, instPtr[15:0]};
        fieldSel   = SEL_IP;
        fieldValid = 1'b1;
      end
      3'd5: begin
        slotVal    = wideQ ? opdAddr : {16'h0, opdAddr[15:0]};
        fieldSel   = SEL_OPD;
        fieldValid = 1'b1;
      end
      default: begin slotVal = '0; fieldValid = 1'b0; end
    endcase
    if (strb.inRegs) begin
      fieldSel   = 4'(regIdx);
      fieldValid = 1'b1;
    end
  end

  always_comb begin
    if (strb.inRegs) begin
      fieldFirst = (regByte == '0);
      fieldEnd   = (regByte == RB_LAST);
      pos        = regByte;
    end else if (wideQ) begin
      fieldFirst = (envCnt[1:0] == 2'd0);
      fieldEnd   = (envCnt[1:0] == 2'd3);
      pos        = RB_W'(byteSel);
    end else begin
      fieldFirst = ~envCnt[0];
      fieldEnd   = envCnt[0];
      pos        = RB_W'(byteSel);
    end
  end

  // Restore assembly: a field's first byte clears the collector
  always_comb begin
    asmNext = fieldFirst ? '0 : asmQ;
    asmNext[{pos, 3'b000} +: 8] = memRdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ   <= '0;
      offQ    <= '0;
      wideQ   <= 1'b0;
      envCnt  <= '0;
      regByte <= '0;
      regIdx  <= '0;
      asmQ    <= '0;
      wrPendQ <= 1'b0;
      wrSelQ  <= '0;
    end else begin
      wrPendQ <= strb.beat && !isWrite && fieldEnd && fieldValid;
      if (strb.beat) wrSelQ <= fieldSel;
      if (strb.load) begin
        baseQ   <= baseAddr;
        wideQ   <= wide32;
        offQ    <= '0;
        envCnt  <= '0;
        regByte <= '0;
        regIdx  <= '0;
      end else if (strb.beat) begin
        offQ <= offQ + 1'b1;
        asmQ <= asmNext;
        if (!strb.inRegs) begin
          envCnt <= envCnt + 1'b1;
        end else if (regByte == RB_LAST) begin
          regByte <= '0;
          regIdx  <= regIdx + 1'b1;
        end else begin
          regByte <= regByte + 1'b1;
        end
      end
    end
  end

  assign memAddr  = baseQ + offQ;
  assign memWdata = strb.inRegs ? rfRdData[{regByte, 3'b000} +: 8]
                                : slotVal[{byteSel, 3'b000} +: 8];
  assign rfRdIdx  = regIdx;
  assign rfWrEn   = wrPendQ;
  assign rfWrSel  = wrSelQ;

  always_comb begin
    rfWrData = asmQ;
    if (wrSelQ == SEL_CTL || wrSelQ == SEL_STAT || wrSelQ == SEL_TAG)
      rfWrData = REG_W'(asmQ[15:0]);
  end

endmodule

// File: rtl/fpu_state_xfer.sv
module fpu_state_xfer
  import fpst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  op,
  input  logic                        wide32,
  input  logic [ADDR_W-1:0]           baseAddr,
  output logic                        busy,
  output logic                        done,
  output logic                        initPulse,
  output logic                        memReq,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [7:0]                  memWdata,
  input  logic [7:0]                  memRdata,
  input  logic                        memAck,
  input  logic [15:0]                 ctlWord,
  input  logic [15:0]                 statWord,
  input  logic [15:0]                 tagWord,
  input  logic [31:0]                 instPtr,
  input  logic [31:0]                 opdAddr,
  output logic [$clog2(NUM_REGS)-1:0] rfRdIdx,
  input  logic [REG_W-1:0]            rfRdData,
  output logic                        rfWrEn,
  output logic [3:0]                  rfWrSel,
  output logic [REG_W-1:0]            rfWrData
);

  seqStrobe_t strb;
  logic       envLast, regLast;

  fpst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opIn     (op),
    .envLast  (envLast),
    .regLast  (regLast),
    .memAck   (memAck),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .initPulse(initPulse),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  fpst_dp #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .isWrite (memWe),
    .baseAddr(baseAddr),
    .wide32  (wide32),
    .ctlWord (ctlWord),
    .statWord(statWord),
    .tagWord (tagWord),
    .instPtr (instPtr),
    .opdAddr (opdAddr),
    .rfRdData(rfRdData),
    .memRdata(memRdata),
    .envLast (envLast),
    .regLast (regLast),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .rfRdIdx (rfRdIdx),
    .rfWrEn  (rfWrEn),
    .rfWrSel (rfWrSel),
    .rfWrData(rfWrData)
  );

endmodule

// File: rtl/fpu_state_xfer_chk.sv
module fpu_state_xfer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op,
  input logic              wide32,
  input logic              busy,
  input logic              done,
  input logic              initPulse,
  input logic              memReq,
  input logic              memAck,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              rfWrEn
);

  logic [7:0] beatCnt, expLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatCnt <= '0;
      expLen  <= '0;
    end else if (start && !busy) begin
      beatCnt <= '0;
      expLen  <= (op[1] ? 8'd0 : 8'd80) + (wide32 ? 8'd28 : 8'd14);
    end else if (memReq && memAck) begin
      beatCnt <= beatCnt + 8'd1;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && (!memWe || $stable(memWdata))));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(memReq && memAck) && memReq) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beatCnt == expLen));

  p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    initPulse |-> (done && memWe && expLen > 8'd28));

  p_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |-> !memWe);

endmodule

bind fpu_state_xfer fpu_state_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .wide32   (wide32),
  .busy     (busy),
  .done     (done),
  .initPulse(initPulse),
  .memReq   (memReq),
  .memAck   (memAck),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .rfWrEn   (rfWrEn)
);

// File: tb/fpu_state_xfer_test.sv
module fpu_state_xfer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        wide32 = 1'b1;
  logic [31:0] baseAddr = '0;
  logic        busy, done, initPulse, memReq, memWe, memAck, rfWrEn;
  logic [31:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic [2:0]  rfRdIdx;
  logic [79:0] rfRdData, rfWrData;
  logic [3:0]  rfWrSel;

  // Register-file model
  logic [15:0] mCtl, mStat, mTag;
  logic [31:0] mIp, mOpd;
  logic [79:0] mRegs [8];
  logic [15:0] pCtl, pStat, pTag;
  logic [31:0] pIp, pOpd;
  logic [79:0] pRegs [8];
  logic        presetEn = 1'b0;

  // Memory model
  logic [7:0]  mem [256];
  logic        fillEn = 1'b0;
  logic [7:0]  fillSeed = 8'd0;
  logic        stall = 1'b0;
  logic [31:0] cyc = '0;

  // Event counters
  logic        clrCnt = 1'b0;
  int          beatCnt, doneCnt, initCnt, regWrCnt, memWrCnt;

  int nVec = 0;
  int nBad = 0;

  // Snapshot used for expected save image
  logic [15:0] sCtl, sStat, sTag;
  logic [31:0] sIp, sOpd;
  logic [79:0] sRegs [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memAck   = memReq && (!stall || cyc[0]);
  assign memRdata = mem[memAddr[7:0]];
  assign rfRdData = mRegs[rfRdIdx];

  fpu_state_xfer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide32(wide32),
    .baseAddr(baseAddr), .busy(busy), .done(done), .initPulse(initPulse),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .ctlWord(mCtl), .statWord(mStat),
    .tagWord(mTag), .instPtr(mIp), .opdAddr(mOpd), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrSel(rfWrSel), .rfWrData(rfWrData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (presetEn) begin
      mCtl <= pCtl; mStat <= pStat; mTag <= pTag; mIp <= pIp; mOpd <= pOpd;
      for (int r = 0; r < 8; r++) mRegs[r] <= pRegs[r];
    end else begin
      if (initPulse) begin
        mCtl <= 16'h037F; mStat <= 16'h0; mTag <= 16'hFFFF; mIp <= '0; mOpd <= '0;
      end
      if (rfWrEn) begin
        case (rfWrSel)
          4'd8:    mCtl  <= rfWrData[15:0];
          4'd9:    mStat <= rfWrData[15:0];
          4'd10:   mTag  <= rfWrData[15:0];
          4'd11:   mIp   <= rfWrData[31:0];
          4'd12:   mOpd  <= rfWrData[31:0];
          default: if (rfWrSel < 4'd8) mRegs[rfWrSel[2:0]] <= rfWrData;
        endcase
      end
    end
    if (fillEn) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7) + fillSeed;
    end else if (memReq && memAck && memWe) begin
      mem[memAddr[7:0]] <= memWdata;
    end
    if (clrCnt) begin
      beatCnt <= 0; doneCnt <= 0; initCnt <= 0; regWrCnt <= 0; memWrCnt <= 0;
    end else begin
      if (memReq && memAck) beatCnt <= beatCnt + 1;
      if (memReq && memAck && memWe) memWrCnt <= memWrCnt + 1;
      if (done) doneCnt <= doneCnt + 1;
      if (initPulse) initCnt <= initCnt + 1;
      if (rfWrEn && rfWrSel < 4'd8) regWrCnt <= regWrCnt + 1;
    end
  end

  function automatic logic [7:0] patByte(int addr);
    return 8'(addr * 7) + fillSeed;
  endfunction

  function automatic logic [79:0] patLE(int addr, int n);
    logic [79:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = patByte(addr + k);
    return v;
  endfunction

  // Expected image byte from the requirements (R5, R6, R7)
  function automatic logic [7:0] expByte(bit w, int off);
    int envLen = w ? 28 : 14;
    int slot, bsel;
    logic [31:0] v;
    if (off < envLen) begin
      slot = w ? off / 4 : off / 2;
      bsel = w ? off % 4 : off % 2;
      case (slot)
        0: v = {16'h0, sCtl};
        1: v = {16'h0, sStat};
        2: v = {16'h0, sTag};
        3: v = sIp;
        5: v = sOpd;
        default: v = '0;
      endcase
      return v[8*bsel +: 8];
    end
    return sRegs[(off - envLen) / 10][8*((off - envLen) % 10) +: 8];
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic preset(int k);
    pCtl = 16'h1A2B + 16'(k); pStat = 16'h3C4D; pTag = 16'h5E6F - 16'(k);
    pIp = 32'h89AB_CDEF ^ 32'(k); pOpd = 32'h1357_9BDF + 32'(k);
    for (int r = 0; r < 8; r++) pRegs[r] = {8'(8'hA0 + r), 72'h01_2345_6789_ABCD_EF12} + 80'(k * 3 + r);
    sCtl = pCtl; sStat = pStat; sTag = pTag; sIp = pIp; sOpd = pOpd;
    for (int r = 0; r < 8; r++) sRegs[r] = pRegs[r];
    presetEn = 1'b1; @(negedge clk); presetEn = 1'b0;
  endtask

  task automatic fill(logic [7:0] seed);
    fillSeed = seed; fillEn = 1'b1; @(negedge clk); fillEn = 1'b0;
  endtask

  task automatic runXfer(logic [1:0] o, bit w, int b, bit stl, bit poke);
    int t = 0;
    stall = stl;
    clrCnt = 1'b1; @(negedge clk); clrCnt = 1'b0;
    op = o; wide32 = w; baseAddr = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", 80'(busy), 80'(1));
    if (poke) begin
      repeat (3) @(negedge clk);
      op = 2'd0; wide32 = ~w; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL R2 done never seen: got 0 expected 1");
    end else begin
      chk("R2 busy low with done", 80'(busy), 80'(0));
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", 80'(busy), 0);
    chk("R1 done", 80'(done), 0);
    chk("R1 initPulse", 80'(initPulse), 0);
    chk("R1 memReq", 80'(memReq), 0);
    chk("R1 rfWrEn", 80'(rfWrEn), 0);
  endtask

  task automatic t_full_save(bit w, int b, bit stl);
    int len = w ? 108 : 94;
    int envLen = w ? 28 : 14;
    fill(8'h11); preset(w ? 1 : 2);
    runXfer(2'd0, w, b, stl, 1'b0);
    for (int off = 0; off < len; off++) begin
      if (off < envLen) chk(w ? "R5 env byte" : "R6 env byte", 80'(mem[b + off]), 80'(expByte(w, off)));
      else chk("R7 register byte", 80'(mem[b + off]), 80'(expByte(w, off)));
    end
    chk("R7 byte past image", 80'(mem[b + len]), 80'(patByte(b + len)));
    chk("R3 byte before base", 80'(mem[b - 1]), 80'(patByte(b - 1)));
    chk("R3 beat count", 80'(beatCnt), 80'(len));
    chk("R4 all beats write", 80'(memWrCnt), 80'(len));
    chk("R2 one done", 80'(doneCnt), 80'(1));
    chk("R8 init after save", 80'(initCnt), 80'(1));
    chk("R8 ctl reinit", 80'(mCtl), 80'(16'h037F));
    chk("R8 tag reinit", 80'(mTag), 80'(16'hFFFF));
  endtask

  task automatic t_env_store(bit w, int b, bit stl, bit poke);
    int envLen = w ? 28 : 14;
    fill(8'h5A); preset(w ? 3 : 4);
    runXfer(2'd2, w, b, stl, poke);
    for (int off = 0; off < envLen; off++)
      chk(w ? "R5 env byte" : "R6 env byte", 80'(mem[b + off]), 80'(expByte(w, off)));
    chk("R10 byte past env", 80'(mem[b + envLen]), 80'(patByte(b + envLen)));
    chk("R7 env beat count", 80'(beatCnt), 80'(envLen));
    chk("R8 no init on env store", 80'(initCnt), 80'(0));
    chk("R8 ctl kept", 80'(mCtl), 80'(sCtl));
    if (poke) chk("R2 start while busy ignored", 80'(doneCnt), 80'(1));
  endtask

  task automatic t_restore(bit w, int b, bit full, bit stl);
    int envLen = w ? 28 : 14;
    int len = full ? envLen + 80 : envLen;
    fill(8'hC3); preset(7);
    runXfer(full ? 2'd1 : 2'd3, w, b, stl, 1'b0);
    if (w) begin
      chk("R9 ctl", 80'(mCtl), patLE(b + 0, 2));
      chk("R9 stat", 80'(mStat), patLE(b + 4, 2));
      chk("R9 tag", 80'(mTag), patLE(b + 8, 2));
      chk("R9 ip", 80'(mIp), patLE(b + 12, 4));
      chk("R9 opd", 80'(mOpd), patLE(b + 20, 4));
    end else begin
      chk("R9 ctl", 80'(mCtl), patLE(b + 0, 2));
      chk("R9 stat", 80'(mStat), patLE(b + 2, 2));
      chk("R9 tag", 80'(mTag), patLE(b + 4, 2));
      chk("R9 ip zero-extended", 80'(mIp), patLE(b + 6, 2));
      chk("R9 opd zero-extended", 80'(mOpd), patLE(b + 10, 2));
    end
    for (int r = 0; r < 8; r++)
      chk(full ? "R9 data register" : "R10 register untouched",
          mRegs[r], full ? patLE(b + envLen + 10 * r, 10) : sRegs[r]);
    chk("R7 beat count", 80'(beatCnt), 80'(len));
    chk("R10 no memory write", 80'(memWrCnt), 80'(0));
    chk("R9 register writes", 80'(regWrCnt), 80'(full ? 8 : 0));
    chk("R8 no init on restore", 80'(initCnt), 80'(0));
  endtask

  task automatic t_roundtrip();
    fill(8'h27); preset(9);
    runXfer(2'd0, 1'b1, 40, 1'b1, 1'b0);
    preset(12);
    runXfer(2'd1, 1'b1, 40, 1'b0, 1'b0);
    chk("R9 roundtrip ctl", 80'(mCtl), 80'(16'h1A2B + 16'd9));
    chk("R9 roundtrip ip", 80'(mIp), 80'(32'h89AB_CDEF ^ 32'd9));
    chk("R9 roundtrip opd", 80'(mOpd), 80'(32'h1357_9BDF + 32'd9));
    chk("R9 roundtrip reg5", mRegs[5], {8'hA5, 72'h01_2345_6789_ABCD_EF12} + 80'(27 + 5));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nVec++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_save(1'b1, 16, 1'b0);
    t_full_save(1'b0, 20, 1'b1);
    t_env_store(1'b1, 8, 1'b0, 1'b0);
    t_env_store(1'b0, 30, 1'b1, 1'b1);
    t_env_store(1'b1, 50, 1'b1, 1'b1);
    t_restore(1'b1, 12, 1'b1, 1'b0);
    t_restore(1'b0, 24, 1'b1, 1'b1);
    t_restore(1'b1, 60, 1'b0, 1'b1);
    t_restore(1'b0, 70, 1'b0, 1'b0);
    t_roundtrip();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule